// File: doc/BRIEF.md
# Pin Edge Event and Interrupt Controller

This block watches sixteen input pins, grouped as two banks of eight, and records a selected transition on each pin. Every pin has its own two-bit sensitivity field that chooses no detection, rising edges, falling edges or both. A detected transition always latches into the bank's event status register. It also latches into the bank's interrupt source register when the pin's interrupt enable bit is set. An active-low interrupt line is asserted whenever any interrupt source bit is pending.

A simple synchronous register port sets up the sensitivities, the enables and a small control register. The same port reads back every register and the filtered pin levels. Pending bits are released by writing ones. Clearing an event bit also drops its interrupt bit, and clearing an interrupt bit also drops its event bit. Reprogramming a pin's sensitivity to a new value discards that pin's pending state. Under a control bit, reading a bank's pin levels clears that bank's interrupt bits.

Each raw pin passes through a two-flop synchroniser. An optional debounce filter follows, which accepts a new level only after it has been steady for a set number of clocks.

Top module: `gpioEdgeIrq`

## Requirements
- R1: After reset, the event registers (address 0x6 for pins 7:0, 0x7 for pins 15:8) and the interrupt registers (0x8, 0x9) read 0x00, and irqN is high.
- R2: Sensitivity register k (address k, for k = 0 to 3) holds pins 4k to 4k+3, with pin n in bits 2(n mod 4)+1 : 2(n mod 4). The code 00 detects nothing, 01 rising edges, 10 falling edges and 11 both. With debounce off, a pin change driven before clock edge 1 sets its event bit at clock edge 3.
- R3: An event bit sets on its pin's configured edge whatever the value of the interrupt enable.
- R4: An interrupt bit sets on its pin's configured edge only when the pin's enable bit is 1. The enable registers are at 0x4 for pins 7:0 and 0x5 for pins 15:8.
- R5: Writing a 1 to an interrupt register bit clears that bit and the matching event bit. Writing a 0 leaves the bit unchanged.
- R6: Writing a 1 to an event register bit clears that bit and the matching interrupt bit.
- R7: Writing a pin's sensitivity field with a different value clears that pin's event and interrupt bits. Writing the same value changes nothing.
- R8: irqN is low while any interrupt bit is set and high when none is set.
- R9: The control register is at address 0xC. When its bit 0 is 0, a read of a bank's level register (0xA for pins 7:0, 0xB for pins 15:8) clears that bank's interrupt bits and leaves the event bits set. When bit 0 is 1, such a read clears nothing.
- R10: A configured edge and a write-one-to-clear on the same bit in the same cycle leave that bit set.
- R11: When control bit 1 is 1, a new pin level is accepted only after it has stayed steady for DEB_CYCLES (default 4) consecutive synchronised samples, so a 2-cycle pulse produces no event. When bit 1 is 0, a 2-cycle pulse is detected.
- R12: The level registers return the filtered level of each pin in the bank, with pin 8b+i at bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 16 | Raw asynchronous pin levels |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (used by clear-on-read) |
| addr | input | 4 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr, combinational |
| irqN | output | 1 | Active-low interrupt request |

## Verification
A corrupt event or interrupt bit shows up directly in the register readback, and a pending interrupt bit also shows as a wrong irqN level one clock after the faulty update. The bench predicts each pin's detected edges from its own model of sensitivity, enable and pin history. It then compares the status registers and irqN after every step of random pin activity and random clears, so an error in cross-clearing or edge classification appears within one iteration. The directed cases pin down the exact edge at which an event appears, the clear-versus-set collision and the debounce window, where an off-by-one in the pipeline or counter would move the result by a cycle.

// File: rtl/gpioIrqPkg.sv
package gpioIrqPkg;
  localparam int BANK_W = 8;
  localparam int BANKS = 2;
  localparam int NPIN = BANK_W * BANKS;
  localparam int REG_W = 8;
  localparam int ADDR_W = 4;
  localparam int FIELDS_PER_REG = REG_W / 2;
  localparam int SENSE_REGS = NPIN / FIELDS_PER_REG;
  localparam int ADDR_MASK0 = SENSE_REGS;
  localparam int ADDR_EVENT0 = ADDR_MASK0 + BANKS;
  localparam int ADDR_IRQ0 = ADDR_EVENT0 + BANKS;
  localparam int ADDR_DATA0 = ADDR_IRQ0 + BANKS;
  localparam int ADDR_CTRL = ADDR_DATA0 + BANKS;

  typedef enum logic [1:0] {
    SENSE_NONE = 2'b00,
    SENSE_RISE = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  typedef struct packed {
    logic [NPIN-1:0] clrEvent;
    logic [NPIN-1:0] clrIrq;
    logic [NPIN-1:0] senseChg;
    logic [NPIN-1:0] readClr;
  } strobe_t;
endpackage

// File: rtl/gpioPinFilter.sv
module gpioPinFilter #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinRaw,
  input  logic debEn,
  output logic level,
  output logic change
);
  localparam int CNT_W = $clog2(DEB_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0] stableCnt;
  logic syncOut;

  assign syncOut = syncQ[SYNC_STAGES-1];
  assign change = (syncOut != level) && (!debEn || stableCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      stableCnt <= '0;
      level <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], pinRaw};
      if (syncOut == level || change) stableCnt <= '0;
      else stableCnt <= stableCnt + 1'b1;
      if (change) level <= syncOut;
    end
  end

  // R11
  debounce_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (debEn && syncOut != level && stableCnt != CNT_LAST) |=> $stable(level));
endmodule

// File: rtl/gpioIrqCtrl.sv
module gpioIrqCtrl
  import gpioIrqPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [REG_W-1:0]      wrData,
  input  logic [NPIN-1:0]       eventSt,
  input  logic [NPIN-1:0]       irqSrc,
  input  logic [NPIN-1:0]       pinLevel,
  output logic [REG_W-1:0]      rdData,
  output strobe_t               strobes,
  output logic [2*NPIN-1:0]     senseVec,
  output logic [NPIN-1:0]       maskVec,
  output logic                  debEn
);
  logic keepIrq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      senseVec <= '0;
      maskVec <= '0;
      keepIrq <= 1'b0;
      debEn <= 1'b0;
    end else if (wrEn) begin
      for (int k = 0; k < SENSE_REGS; k++)
        if (addr == ADDR_W'(k)) senseVec[k*REG_W +: REG_W] <= wrData;
      for (int b = 0; b < BANKS; b++)
        if (addr == ADDR_W'(ADDR_MASK0 + b)) maskVec[b*BANK_W +: BANK_W] <= wrData;
      if (addr == ADDR_W'(ADDR_CTRL)) begin
        keepIrq <= wrData[0];
        debEn <= wrData[1];
      end
    end
  end

  always_comb begin
    strobes = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (wrEn && addr == ADDR_W'(ADDR_EVENT0 + b))
        strobes.clrEvent[b*BANK_W +: BANK_W] = wrData;
      if (wrEn && addr == ADDR_W'(ADDR_IRQ0 + b))
        strobes.clrIrq[b*BANK_W +: BANK_W] = wrData;
      if (rdEn && !keepIrq && addr == ADDR_W'(ADDR_DATA0 + b))
        strobes.readClr[b*BANK_W +: BANK_W] = '1;
    end
    for (int k = 0; k < SENSE_REGS; k++)
      for (int j = 0; j < FIELDS_PER_REG; j++)
        if (wrEn && addr == ADDR_W'(k))
          strobes.senseChg[k*FIELDS_PER_REG + j] =
            (wrData[2*j +: 2] != senseVec[(k*FIELDS_PER_REG + j)*2 +: 2]);
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < SENSE_REGS; k++)
      if (addr == ADDR_W'(k)) rdData = senseVec[k*REG_W +: REG_W];
    for (int b = 0; b < BANKS; b++) begin
      if (addr == ADDR_W'(ADDR_MASK0 + b)) rdData = maskVec[b*BANK_W +: BANK_W];
      if (addr == ADDR_W'(ADDR_EVENT0 + b)) rdData = eventSt[b*BANK_W +: BANK_W];
      if (addr == ADDR_W'(ADDR_IRQ0 + b)) rdData = irqSrc[b*BANK_W +: BANK_W];
      if (addr == ADDR_W'(ADDR_DATA0 + b)) rdData = pinLevel[b*BANK_W +: BANK_W];
    end
    if (addr == ADDR_W'(ADDR_CTRL)) rdData = {{(REG_W-2){1'b0}}, debEn, keepIrq};
  end

  // R7
  sense_strobe_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr < ADDR_W'(SENSE_REGS)) |-> (strobes.senseChg == '0));

  // R9
  keep_no_readclr_chk: assert property (@(posedge clk) disable iff (!rstN)
    keepIrq |-> (strobes.readClr == '0));
endmodule

// File: rtl/gpioIrqDatapath.sv
module gpioIrqDatapath
  import gpioIrqPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NPIN-1:0]   pinIn,
  input  strobe_t           strobes,
  input  logic [2*NPIN-1:0] senseVec,
  input  logic [NPIN-1:0]   maskVec,
  input  logic              debEn,
  output logic [NPIN-1:0]   eventSt,
  output logic [NPIN-1:0]   irqSrc,
  output logic [NPIN-1:0]   pinLevel
);
  logic [NPIN-1:0] pinChange;
  logic [NPIN-1:0] setVec;
  logic [NPIN-1:0] senseNone;
  logic [NPIN-1:0] clrBoth;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    gpioPinFilter #(.SYNC_STAGES(SYNC_STAGES), .DEB_CYCLES(DEB_CYCLES)) u_filter (
      .clk(clk), .rstN(rstN), .pinRaw(pinIn[i]), .debEn(debEn),
      .level(pinLevel[i]), .change(pinChange[i])
    );
  end

  always_comb begin
    for (int i = 0; i < NPIN; i++) begin
      sense_e mode;
      mode = sense_e'(senseVec[2*i +: 2]);
      senseNone[i] = (mode == SENSE_NONE);
      unique case (mode)
        SENSE_RISE: setVec[i] = pinChange[i] & ~pinLevel[i];
        SENSE_FALL: setVec[i] = pinChange[i] & pinLevel[i];
        SENSE_BOTH: setVec[i] = pinChange[i];
        default:    setVec[i] = 1'b0;
      endcase
    end
  end

  assign clrBoth = strobes.clrEvent | strobes.clrIrq | strobes.senseChg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eventSt <= '0;
      irqSrc <= '0;
    end else begin
      eventSt <= setVec | (eventSt & ~clrBoth);
      irqSrc <= (setVec & maskVec) | (irqSrc & ~(clrBoth | strobes.readClr));
    end
  end

  // R5
  irq_within_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqSrc & ~eventSt) == '0);

  // R4
  masked_no_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((irqSrc & ~$past(irqSrc) & ~$past(maskVec)) == '0));

  // R2
  none_no_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((eventSt & ~$past(eventSt) & $past(senseNone)) == '0));

  // R7
  sense_chg_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    |(strobes.senseChg & ~setVec) |=> ((eventSt & $past(strobes.senseChg & ~setVec)) == '0));

  // R9
  read_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    |(strobes.readClr & ~setVec) |=> ((irqSrc & $past(strobes.readClr & ~setVec)) == '0));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    |setVec |=> ((eventSt & $past(setVec)) == $past(setVec)));
endmodule

// File: rtl/gpioEdgeIrq.sv
module gpioEdgeIrq
  import gpioIrqPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NPIN-1:0]   pinIn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  output logic              irqN
);
  strobe_t strobes;
  logic [2*NPIN-1:0] senseVec;
  logic [NPIN-1:0] maskVec;
  logic [NPIN-1:0] eventSt;
  logic [NPIN-1:0] irqSrc;
  logic [NPIN-1:0] pinLevel;
  logic debEn;

  gpioIrqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .eventSt(eventSt), .irqSrc(irqSrc), .pinLevel(pinLevel), .rdData(rdData),
    .strobes(strobes), .senseVec(senseVec), .maskVec(maskVec), .debEn(debEn)
  );

  gpioIrqDatapath #(.SYNC_STAGES(SYNC_STAGES), .DEB_CYCLES(DEB_CYCLES)) u_datapath (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .strobes(strobes), .senseVec(senseVec),
    .maskVec(maskVec), .debEn(debEn), .eventSt(eventSt), .irqSrc(irqSrc),
    .pinLevel(pinLevel)
  );

  assign irqN = ~|irqSrc;

  // R8
  irq_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|irqSrc) |-> !irqN);
endmodule

// File: tb/gpioEdgeIrq_bench.sv
module gpioEdgeIrq_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] pinIn = '0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic irqN;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [15:0] eventM, irqM, maskM, pinsM;
  logic [31:0] senseM;
  logic [7:0] v;

  gpioEdgeIrq u_gpioEdgeIrq (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqN(irqN)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a[3:0]; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    addr = a[3:0]; rdEn = 1'b1;
    #2 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic peek(input int a, output logic [7:0] d);
    addr = a[3:0];
    #2 d = rdData;
  endtask

  task automatic setPins(input logic [15:0] p);
    @(negedge clk);
    pinIn = p;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] edgeHits(input logic [15:0] oldP, input logic [15:0] newP,
                                           input logic [31:0] sense);
    logic [15:0] h;
    for (int i = 0; i < 16; i++) begin
      h[i] = (sense[2*i] && !oldP[i] && newP[i]) || (sense[2*i+1] && oldP[i] && !newP[i]);
    end
    return h;
  endfunction

  task automatic readStatus(output logic [15:0] ev, output logic [15:0] iq);
    logic [7:0] a, b;
    rd(6, a); rd(7, b); ev = {b, a};
    rd(8, a); rd(9, b); iq = {b, a};
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] ev, iq;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readStatus(ev, iq);
    chk("R1 event", ev, 16'h0);
    chk("R1 irq", iq, 16'h0);
    chk("R1 irqN", {15'h0, irqN}, 16'h1);

    // R2 pin0 rising, enable pin0; exact latency
    wr(0, 8'h01); wr(4, 8'h01);
    setPins(16'h0001);
    waitCyc(2);
    peek(6, v); chk("R2 before edge3", {8'h0, v}, 16'h0);
    waitCyc(1);
    peek(6, v); chk("R2 at edge3", {8'h0, v}, 16'h1);
    peek(8, v); chk("R4 enabled irq", {8'h0, v}, 16'h1);
    chk("R8 irqN low", {15'h0, irqN}, 16'h0);

    // R3 pin9 falling, not enabled (reg2 field1 = bits 3:2)
    setPins(16'h0201); waitCyc(6);
    wr(2, 8'h08);
    setPins(16'h0001); waitCyc(6);
    rd(7, v); chk("R3 event w/o enable", {8'h0, v}, 16'h02);
    rd(9, v); chk("R4 masked irq", {8'h0, v}, 16'h0);
    wr(7, 8'h02);

    // R5 w1c irq clears both; zeros do nothing
    wr(8, 8'h00);
    rd(8, v); chk("R5 zero write keeps", {8'h0, v}, 16'h1);
    wr(8, 8'h01);
    readStatus(ev, iq);
    chk("R5 event cleared", ev, 16'h0);
    chk("R5 irq cleared", iq, 16'h0);
    chk("R8 irqN high", {15'h0, irqN}, 16'h1);

    // R6 w1c event clears irq
    setPins(16'h0000); waitCyc(5);
    setPins(16'h0001); waitCyc(5);
    rd(8, v); chk("R6 setup irq", {8'h0, v}, 16'h1);
    wr(6, 8'h01);
    readStatus(ev, iq);
    chk("R6 irq via event", iq, 16'h0);
    chk("R6 event", ev, 16'h0);

    // R7 sense rewrite
    setPins(16'h0000); waitCyc(5);
    setPins(16'h0001); waitCyc(5);
    wr(0, 8'h01);
    rd(6, v); chk("R7 same value keeps", {8'h0, v}, 16'h1);
    wr(0, 8'h03);
    readStatus(ev, iq);
    chk("R7 changed clears event", ev, 16'h0);
    chk("R7 changed clears irq", iq, 16'h0);

    // R9 read-clear on, R12 level readback
    setPins(16'h0000); waitCyc(5);
    rd(10, v); chk("R12 level bank0", {8'h0, v}, 16'h0);
    rd(9, v);
    readStatus(ev, iq);
    chk("R9 setup event", ev, 16'h1);
    rd(10, v);
    readStatus(ev, iq);
    chk("R9 read clears irq", iq, 16'h0);
    chk("R9 event stays", ev, 16'h1);
    wr(12, 8'h01);
    wr(6, 8'h01);
    setPins(16'h8001); waitCyc(5);
    rd(11, v); chk("R12 level bank1", {8'h0, v}, 16'h80);
    rd(10, v); chk("R12 level bank0 hi", {8'h0, v}, 16'h01);
    rd(8, v); chk("R9 keep on read", {8'h0, v}, 16'h1);

    // R10 falling edge coincident with w1c (pin0 sense both)
    @(negedge clk); pinIn = 16'h8000;
    @(negedge clk);
    @(negedge clk); wrEn = 1'b1; addr = 4'd6; wrData = 8'h01;
    @(negedge clk); wrEn = 1'b0;
    rd(6, v); chk("R10 set wins", {8'h0, v}, 16'h1);
    wr(6, 8'hFF); wr(7, 8'hFF);

    // R11 debounce: pin1 rising (reg0 = 0x07)
    wr(0, 8'h07); wr(12, 8'h03);
    setPins(16'h8002); waitCyc(2); setPins(16'h8000); waitCyc(10);
    rd(6, v); chk("R11 short pulse filtered", {8'h0, v}, 16'h0);
    setPins(16'h8002); waitCyc(12);
    rd(6, v); chk("R11 steady accepted", {8'h0, v}, 16'h2);
    wr(12, 8'h01);
    setPins(16'h8000); waitCyc(6); wr(6, 8'hFF);
    setPins(16'h8002); waitCyc(2); setPins(16'h8000); waitCyc(6);
    rd(6, v); chk("R11 pulse seen w/o debounce", {8'h0, v}, 16'h2);

    // Random phase: R3 R4 R5 R6 R7 R8 against model
    void'($urandom(32'h5eed_1234));
    pinsM = 16'h8000;
    senseM = {$urandom};
    for (int k = 0; k < 4; k++) wr(k, senseM[8*k +: 8]);
    maskM = 16'($urandom);
    wr(4, maskM[7:0]); wr(5, maskM[15:8]);
    wr(6, 8'hFF); wr(7, 8'hFF);
    eventM = '0; irqM = '0;
    for (int it = 0; it < 60; it++) begin
      logic [15:0] np;
      int sel;
      np = 16'($urandom);
      setPins(np); waitCyc(6);
      eventM |= edgeHits(pinsM, np, senseM);
      irqM |= edgeHits(pinsM, np, senseM) & maskM;
      pinsM = np;
      readStatus(ev, iq);
      chk("R3 random event", ev, eventM);
      chk("R4 random irq", iq, irqM);
      chk("R8 random irqN", {15'h0, irqN}, {15'h0, (irqM == 0)});
      sel = $urandom_range(0, 5);
      v = 8'($urandom);
      case (sel)
        0, 1: begin
          wr(6 + (sel & 1), v);
          eventM &= ~(16'(v) << (8 * (sel & 1)));
          irqM &= ~(16'(v) << (8 * (sel & 1)));
        end
        2, 3: begin
          wr(8 + (sel & 1), v);
          eventM &= ~(16'(v) << (8 * (sel & 1)));
          irqM &= ~(16'(v) << (8 * (sel & 1)));
        end
        4: begin
          int k;
          k = $urandom_range(0, 3);
          for (int j = 0; j < 4; j++)
            if (v[2*j +: 2] != senseM[8*k + 2*j +: 2]) begin
              eventM[4*k + j] = 1'b0;
              irqM[4*k + j] = 1'b0;
            end
          senseM[8*k +: 8] = v;
          wr(k, v);
        end
        default: begin
          maskM[7:0] = v;
          wr(4, v);
        end
      endcase
    end
    readStatus(ev, iq);
    chk("R6 final event", ev, eventM);
    chk("R5 final irq", iq, irqM);
    summary();
  end
endmodule